// File: doc/BRIEF.md
# Emergency Stop Input Conditioner

This block conditions an active-low emergency-stop pin and three position-sensor pins for a motor-drive controller. It brings each raw pin into the clock domain through a two-flop synchroniser. It then passes each pin through a digital glitch filter. Software sets the filter's rejection width at run time and can also switch the filter off.

The filtered stop signal takes over the motor-drive bus. While it is asserted, each drive output carries its own programmable safe level in place of the normal drive value. The block also sets a sticky stop flag. Normal drive resumes only after the stop input has returned inactive and software has cleared the flag.

The three sensor inputs use the same filter setting and come out filtered for the rest of the drive logic. All pins here are plain level signals. No stream handshake is used, since nothing is queued or back-pressured.

Top module: `estop_guard`

## Requirements
- R1: `flt_sel` selects the filter width W: 00 gives 4, 01 gives 8, 10 gives 16 and 11 gives 32 clock cycles.
- R2: With `flt_en`=1, a new raw level held for fewer than W consecutive sampling edges is rejected and leaves every output unchanged.
- R3: With `flt_en`=1, a filtered output takes a new level on the edge W+1 edges after the first edge that captures that level at the raw pin, so it changes after W+2 edges counting that first edge. The two synchroniser stages do not count toward W.
- R4: With `flt_en`=0, the filter is bypassed. The filtered output follows the synchronised pin and changes on the second edge after the capture edge, and even a one-cycle pulse gets through.
- R5: `stop_n_raw` is active low. While the filtered stop is asserted, `drv_out` equals `safe_lvl` in the same cycle that the filtered value changes.
- R6: Each bit i of `drv_out` takes bit i of `safe_lvl` while forced, whatever `drv_in` does. A change of `safe_lvl` during a stop shows up on `drv_out` at once.
- R7: `stop_flag` sets on the edge after the filtered stop asserts. `flag_clr` is ignored while the filtered stop is still asserted.
- R8: After the filtered stop has gone inactive, the outputs stay forced until a `flag_clr` pulse clears `stop_flag`. From the next cycle `drv_out` equals `drv_in`.
- R9: Each bit of `sensor_flt` is filtered from the matching bit of `sensor_raw` with the same W and enable as the stop input. Its reset level is 0.
- R10: Out of reset, `stop_flag`=0, `sensor_flt`=0 and `drv_out`=`drv_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n_raw | input | 1 | Raw emergency-stop pin, active low |
| sensor_raw | input | NUM_SENSE (3) | Raw position-sensor pins |
| flt_en | input | 1 | 1 = filter active, 0 = bypass |
| flt_sel | input | 2 | Filter width select |
| safe_lvl | input | NUM_OUT (6) | Per-output level forced during stop |
| flag_clr | input | 1 | Pulse to clear the sticky stop flag |
| drv_in | input | NUM_OUT (6) | Normal drive values |
| drv_out | output | NUM_OUT (6) | Gated drive outputs |
| sensor_flt | output | NUM_SENSE (3) | Filtered sensor levels |
| stop_flag | output | 1 | Sticky stop flag |

## Verification
A filter counter that miscounts moves the edge on which `drv_out` switches to the safe levels by one or more cycles. The bench therefore samples one edge before and one edge on the expected switch point for every width. A counter that fails to restart lets a pulse of W-1 cycles through, and that pulse stays visible on `stop_flag` until it is cleared. Wrong flag logic shows up one cycle after an ignored or accepted clear, as forcing that persists or that drops too early.

// File: rtl/estop_pkg.sv
package estop_pkg;
  localparam int SEL_W   = 2;
  localparam int BASE_LG = 2;
  localparam int CNT_W   = BASE_LG + (1 << SEL_W) - 1;

  function automatic logic [CNT_W-1:0] width_last(input logic [SEL_W-1:0] sel);
    logic [CNT_W:0] w;
    w = (CNT_W+1)'(1) << (BASE_LG + int'(sel));
    return CNT_W'(w - 1);
  endfunction
endpackage

// File: rtl/estop_sync2.sv
module estop_sync2 #(
  parameter int          N       = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/estop_filter.sv
module estop_filter
  import estop_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             q
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim = width_last(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= RST_VAL;
      cnt <= '0;
    end else if (!en) begin
      q   <= d;
      cnt <= '0;
    end else if (d == q) begin
      cnt <= '0;
    end else if (cnt >= lim) begin
      q   <= d;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: with filtering on, a level change needs a full run of differing samples
  a_r2_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> (!$past(en) || ($past(cnt) >= $past(lim))));

  // R4: bypass copies the synchronised input on the next edge
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (q == $past(d)));
endmodule

// File: rtl/estop_guard.sv
module estop_guard
  import estop_pkg::*;
#(
  parameter int NUM_OUT   = 6,
  parameter int NUM_SENSE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stop_n_raw,
  input  logic [NUM_SENSE-1:0] sensor_raw,
  input  logic                 flt_en,
  input  logic [SEL_W-1:0]     flt_sel,
  input  logic [NUM_OUT-1:0]   safe_lvl,
  input  logic                 flag_clr,
  input  logic [NUM_OUT-1:0]   drv_in,
  output logic [NUM_OUT-1:0]   drv_out,
  output logic [NUM_SENSE-1:0] sensor_flt,
  output logic                 stop_flag
);
  localparam int NPIN = NUM_SENSE + 1;
  localparam logic [NPIN-1:0] SYNC_RST = {{NUM_SENSE{1'b0}}, 1'b1};

  logic [NPIN-1:0] pin_sync;
  logic            stop_n_flt;
  logic            stop_act;
  logic            force_safe;

  estop_sync2 #(.N(NPIN), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sensor_raw, stop_n_raw}),
    .q     (pin_sync)
  );

  estop_filter #(.RST_VAL(1'b1)) u_stop_flt (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_sync[0]),
    .en    (flt_en),
    .sel   (flt_sel),
    .q     (stop_n_flt)
  );

  for (genvar g = 0; g < NUM_SENSE; g++) begin : g_sense
    estop_filter #(.RST_VAL(1'b0)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_sync[g+1]),
      .en    (flt_en),
      .sel   (flt_sel),
      .q     (sensor_flt[g])
    );
  end

  assign stop_act = !stop_n_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stop_flag <= 1'b0;
    else if (stop_act) stop_flag <= 1'b1;
    else if (flag_clr) stop_flag <= 1'b0;
  end

  assign force_safe = stop_act | stop_flag;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
    assign drv_out[i] = force_safe ? safe_lvl[i] : drv_in[i];
  end

  // R5: filtered stop forces the safe levels at once
  a_r5_force: assert property (@(posedge clk) disable iff (!rst_n)
    stop_act |-> (drv_out == safe_lvl));

  // R7: flag sets after filtered assertion
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    stop_act |=> stop_flag);

  // R7: flag holds without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && !flag_clr) |=> stop_flag);

  // R8: flag drops only on a clear with the stop inactive
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_flag) |-> ($past(flag_clr) && $past(stop_n_flt)));
endmodule

// File: tb/tb_estop_guard.sv
`timescale 1ns/100ps
module tb_estop_guard;
  localparam int NO = 6;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stop_n_raw;
  logic [NS-1:0] sensor_raw;
  logic          flt_en;
  logic [1:0]    flt_sel;
  logic [NO-1:0] safe_lvl;
  logic          flag_clr;
  logic [NO-1:0] drv_in;
  logic [NO-1:0] drv_out;
  logic [NS-1:0] sensor_flt;
  logic          stop_flag;

  always #2.5 clk = ~clk;

  estop_guard #(.NUM_OUT(NO), .NUM_SENSE(NS)) dut (
    .clk(clk), .rst_n(rst_n), .stop_n_raw(stop_n_raw), .sensor_raw(sensor_raw),
    .flt_en(flt_en), .flt_sel(flt_sel), .safe_lvl(safe_lvl), .flag_clr(flag_clr),
    .drv_in(drv_in), .drv_out(drv_out), .sensor_flt(sensor_flt), .stop_flag(stop_flag)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q_exp[$];
  event  ev_chk;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(ev_chk);
      while (q_exp.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q_exp.pop_front();
        case (it.kind)
          0: act = 32'(drv_out);
          1: act = 32'(stop_flag);
          default: act = 32'(sensor_flt);
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q_exp.push_back(it);
    -> ev_chk;
    #0.1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  // full stop cycle with filter width w, checking the switch edge
  task automatic stop_edge(input int w, input string req);
    stop_n_raw = 1'b0;
    cyc(w + 1);
    chk(0, 32'(drv_in), req);
    cyc(1);
    chk(0, 32'(safe_lvl), req);
  endtask

  task automatic release_all(input int w);
    stop_n_raw = 1'b1;
    cyc(w + 3);
    clear_flag();
    cyc(1);
  endtask

  initial begin
    rst_n = 1'b0; stop_n_raw = 1'b1; sensor_raw = '0; flt_en = 1'b1;
    flt_sel = 2'b00; safe_lvl = 6'b010011; flag_clr = 1'b0; drv_in = 6'h2A;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(1, 32'd0, "R10");
    chk(2, 32'd0, "R10");
    chk(0, 32'h2A, "R10");

    // R2: W=4, pulse of 3 rejected
    stop_n_raw = 1'b0; cyc(3); stop_n_raw = 1'b1;
    cyc(40);
    chk(1, 32'd0, "R2");
    chk(0, 32'(drv_in), "R2");

    // R1/R3/R5: W=8 switch edge
    flt_sel = 2'b01;
    stop_edge(8, "R3");
    cyc(1);
    chk(1, 32'd1, "R7");
    drv_in = 6'h15;
    #0.1;
    chk(0, 32'b010011, "R6");
    safe_lvl = 6'b101100;
    #0.1;
    chk(0, 32'b101100, "R6");
    clear_flag();
    chk(1, 32'd1, "R7");
    chk(0, 32'b101100, "R5");
    // R8: release, still forced until clear
    stop_n_raw = 1'b1;
    cyc(12);
    chk(0, 32'b101100, "R8");
    chk(1, 32'd1, "R8");
    clear_flag();
    chk(1, 32'd0, "R8");
    chk(0, 32'h15, "R8");

    // R1: W=32, pulse 31 rejected, then exact edge
    flt_sel = 2'b11;
    stop_n_raw = 1'b0; cyc(31); stop_n_raw = 1'b1;
    cyc(40);
    chk(1, 32'd0, "R1");
    stop_edge(32, "R1");
    release_all(32);
    chk(0, 32'h15, "R8");

    // R9: sensors, W=16
    flt_sel = 2'b10;
    sensor_raw = 3'b101;
    cyc(17);
    chk(2, 32'd0, "R9");
    cyc(1);
    chk(2, 32'b101, "R9");
    sensor_raw = 3'b111; cyc(15); sensor_raw = 3'b101;
    cyc(30);
    chk(2, 32'b101, "R9");

    // R1: W=4 exact edge
    flt_sel = 2'b00;
    stop_edge(4, "R1");
    release_all(4);

    // R4: bypass
    flt_en = 1'b0;
    stop_n_raw = 1'b0;
    cyc(2);
    chk(0, 32'(drv_in), "R4");
    cyc(1);
    chk(0, 32'(safe_lvl), "R4");
    release_all(1);
    chk(1, 32'd0, "R4");
    stop_n_raw = 1'b0; cyc(1); stop_n_raw = 1'b1;
    cyc(6);
    chk(1, 32'd1, "R4");
    chk(0, 32'(safe_lvl), "R4");

    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule